// File: doc/BRIEF.md
# Prescaled Baud Clock Generator

This block turns a fast input clock into the 16x oversampling clock that a serial transmitter and receiver run from. The input clock first passes through a prescaler that divides by 1, 3, 4 or 5. A divisor stage then divides the prescaled rate by one of seventeen ratios, or passes it through unchanged. Three of those ratios are fractional: 16/3, 32/3 and 58/3. The stage produces them by cycling through a fixed pattern of three period lengths. For example, an input near 1.8432 MHz with a prescale of 3 gives 614.4 kHz. Dividing that by 2 gives the 16x clock for 19.2 kbaud, and dividing it by 768 gives the 16x clock for 50 baud.

Three outputs are produced. The first is a single-cycle enable at the 16x rate, for logic clocked by the input clock. The second is a registered square wave at the same rate. The third is a clock-out pin that carries either the raw input clock or that square wave. All settings come from one 8-bit select register, written through a simple write strobe.

The divisor stage is built around a three-phase sequencer with states PH_A, PH_B and PH_C. It advances only at the end of a fractional period. The transitions are named ADV_AB, ADV_BC and ADV_CA. A restart (a register write or reset) returns it to PH_A.

Top module: `prescaled_baud_gen`

## Requirements
- R1: Select bits 1:0 set the prescale ratio P: 00 gives 1, 01 gives 3, 10 gives 4, 11 gives 5.
- R2: Select bits 6:2 set an integer divisor L, which gives a tick period of P*L input cycles. The codes are: 00000=2, 00001=4, 00011=8, 00101=16, 00111=22, 01000=32, 01001=64, 01010=128, 01011=192, 01100=256, 01101=288, 01110=352, 01111=512, 10000=768.
- R3: The fractional codes repeat a pattern of three periods, measured in prescaled ticks and starting from PH_A after a restart. Code 00010 repeats 5,5,6. Code 00100 repeats 11,11,10. Code 00110 repeats 19,19,20.
- R4: Divisor code 11111 bypasses the divisor, so baud_tick fires every P cycles. In this mode baud_clk is high for ceil(P/2) of every P cycles.
- R5: Divisor codes 10001 through 11110 behave exactly like divide by 2.
- R6: Outside bypass, baud_clk is high for the first ceil(L/2) prescaled ticks of each L-tick period. For even L this is a 50% duty cycle.
- R7: Select bit 7 at 0 puts the input clock on clk_out. At 1 it puts baud_clk there. Reset clears bit 7 and keeps bits 6:0.
- R8: A write to the select register restarts the generator. In the next cycle both baud_tick and baud_clk are 0. The first baud_tick appears P*L+1 cycles after the write edge, where L is the first period of the pattern.
- R9: Reset clears the prescaler and divisor counters and drives baud_tick and baud_clk to 0. After reset is released, timing follows the same rule as R8.
- R10: When P is greater than 1, baud_tick is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| sel_wr_en | input | 1 | Write strobe for the select register |
| sel_wr_data | input | 8 | Select value: [1:0] prescale, [6:2] divisor, [7] clock-out source |
| baud_tick | output | 1 | Single-cycle enable at the 16x rate |
| baud_clk | output | 1 | Registered 16x square wave |
| clk_out | output | 1 | Input clock or baud_clk, chosen by select bit 7 |

## Verification
Every output of this block comes from a register, except clk_out in raw mode. A register write or a reset edge therefore shows up on baud_tick and baud_clk one edge later. The first tick follows P*L+1 edges after that write or reset edge, and later ticks follow every P times the current pattern length. The bench advances a behavioural model at the same edge as the design and compares at the opposite clock edge, so each result is read half a cycle after the edge that produced it. Separate gap measurements count the cycles between ticks from the restart onward and compare them with the expected P*L sequence. clk_out in raw mode is sampled inside the high phase of the clock.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

    localparam int SEL_W      = 8;
    localparam int PRE_CODE_W = 2;
    localparam int DIV_CODE_W = 5;
    localparam int PRE_CNT_W  = 3;
    localparam int DIV_CNT_W  = 10;

    typedef enum logic [1:0] {
        DK_BYPASS = 2'd0,
        DK_FIXED  = 2'd1,
        DK_FRAC   = 2'd2
    } div_kind_e;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } phase_e;

    function automatic logic [PRE_CNT_W-1:0] pre_ratio(input logic [PRE_CODE_W-1:0] code);
        unique case (code)
            2'b00:   pre_ratio = PRE_CNT_W'(1);
            2'b01:   pre_ratio = PRE_CNT_W'(3);
            2'b10:   pre_ratio = PRE_CNT_W'(4);
            default: pre_ratio = PRE_CNT_W'(5);
        endcase
    endfunction

    function automatic div_kind_e div_kind(input logic [DIV_CODE_W-1:0] code);
        if (code == 5'b11111)
            div_kind = DK_BYPASS;
        else if (code == 5'b00010 || code == 5'b00100 || code == 5'b00110)
            div_kind = DK_FRAC;
        else
            div_kind = DK_FIXED;
    endfunction

    function automatic logic [DIV_CNT_W-1:0] fixed_len(input logic [DIV_CODE_W-1:0] code);
        case (code)
            5'b00000: fixed_len = DIV_CNT_W'(2);
            5'b00001: fixed_len = DIV_CNT_W'(4);
            5'b00011: fixed_len = DIV_CNT_W'(8);
            5'b00101: fixed_len = DIV_CNT_W'(16);
            5'b00111: fixed_len = DIV_CNT_W'(22);
            5'b01000: fixed_len = DIV_CNT_W'(32);
            5'b01001: fixed_len = DIV_CNT_W'(64);
            5'b01010: fixed_len = DIV_CNT_W'(128);
            5'b01011: fixed_len = DIV_CNT_W'(192);
            5'b01100: fixed_len = DIV_CNT_W'(256);
            5'b01101: fixed_len = DIV_CNT_W'(288);
            5'b01110: fixed_len = DIV_CNT_W'(352);
            5'b01111: fixed_len = DIV_CNT_W'(512);
            5'b10000: fixed_len = DIV_CNT_W'(768);
            default:  fixed_len = DIV_CNT_W'(2);
        endcase
    endfunction

    function automatic logic [DIV_CNT_W-1:0] frac_len(input logic [DIV_CODE_W-1:0] code,
                                                      input phase_e ph);
        logic [DIV_CNT_W-1:0] base;
        logic [DIV_CNT_W-1:0] odd;
        case (code)
            5'b00010: begin base = DIV_CNT_W'(5);  odd = DIV_CNT_W'(6);  end
            5'b00100: begin base = DIV_CNT_W'(11); odd = DIV_CNT_W'(10); end
            default:  begin base = DIV_CNT_W'(19); odd = DIV_CNT_W'(20); end
        endcase
        frac_len = (ph == PH_C) ? odd : base;
    endfunction

endpackage

// File: rtl/bgen_prescaler.sv
module bgen_prescaler
    import bgen_pkg::*;
#(
    parameter int CODE_W = PRE_CODE_W,
    parameter int CNT_W  = PRE_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [CODE_W-1:0] pre_code,
    output logic              pre_tick,
    output logic [CNT_W-1:0]  pre_cnt,
    output logic [CNT_W-1:0]  pre_half
);

    logic [CNT_W-1:0] ratio;

    assign ratio    = pre_ratio(pre_code);
    assign pre_tick = (pre_cnt == ratio - CNT_W'(1));
    assign pre_half = (ratio + CNT_W'(1)) >> 1;

    always_ff @(posedge clk) begin
        if (rst || restart)
            pre_cnt <= '0;
        else if (pre_tick)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + CNT_W'(1);
    end

endmodule

// File: rtl/bgen_divider.sv
module bgen_divider
    import bgen_pkg::*;
#(
    parameter int CODE_W = DIV_CODE_W,
    parameter int CNT_W  = DIV_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              pre_tick,
    input  logic [CODE_W-1:0] div_code,
    output logic              div_last,
    output logic              bypass,
    output logic [CNT_W-1:0]  div_cnt,
    output logic [CNT_W-1:0]  period_len,
    output logic [CNT_W-1:0]  div_half
);

    phase_e    ph_q;
    phase_e    ph_d;
    div_kind_e kind;
    logic      period_end;

    assign kind       = div_kind(div_code);
    assign bypass     = (kind == DK_BYPASS);
    assign div_half   = (period_len + CNT_W'(1)) >> 1;
    assign div_last   = (div_cnt == period_len - CNT_W'(1));
    assign period_end = pre_tick && div_last;

    always_comb begin
        unique case (kind)
            DK_BYPASS: period_len = CNT_W'(1);
            DK_FIXED:  period_len = fixed_len(div_code);
            DK_FRAC:   period_len = frac_len(div_code, ph_q);
            default:   period_len = CNT_W'(2);
        endcase
    end

    // Phase sequencer: next-state logic
    always_comb begin
        ph_d = ph_q;
        if (period_end && kind == DK_FRAC) begin
            unique case (ph_q)
                PH_A:    ph_d = PH_B;   // ADV_AB
                PH_B:    ph_d = PH_C;   // ADV_BC
                PH_C:    ph_d = PH_A;   // ADV_CA
                default: ph_d = PH_A;
            endcase
        end
    end

    // Phase sequencer: state register
    always_ff @(posedge clk) begin
        if (rst || restart)
            ph_q <= PH_A;
        else
            ph_q <= ph_d;
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            div_cnt <= '0;
        else if (pre_tick)
            div_cnt <= div_last ? '0 : div_cnt + CNT_W'(1);
    end

endmodule

// File: rtl/prescaled_baud_gen.sv
module prescaled_baud_gen
    import bgen_pkg::*;
#(
    parameter int SELW   = SEL_W,
    parameter int PCODEW = PRE_CODE_W,
    parameter int DCODEW = DIV_CODE_W,
    parameter int PCNTW  = PRE_CNT_W,
    parameter int DCNTW  = DIV_CNT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel_wr_en,
    input  logic [SELW-1:0] sel_wr_data,
    output logic            baud_tick,
    output logic            baud_clk,
    output logic            clk_out
);

    localparam int MUX_BIT = SELW - 1;

    logic [SELW-1:0]  sel_q;
    logic             pre_tick;
    logic [PCNTW-1:0] pre_cnt;
    logic [PCNTW-1:0] pre_half;
    logic             div_last;
    logic             bypass;
    logic [DCNTW-1:0] div_cnt;
    logic [DCNTW-1:0] period_len;
    logic [DCNTW-1:0] div_half;
    logic             tick_q;
    logic             bclk_q;

    // Select register: divider fields survive reset, mux bit does not
    always_ff @(posedge clk) begin
        if (sel_wr_en)
            sel_q[MUX_BIT-1:0] <= sel_wr_data[MUX_BIT-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel_q[MUX_BIT] <= 1'b0;
        else if (sel_wr_en)
            sel_q[MUX_BIT] <= sel_wr_data[MUX_BIT];
    end

    bgen_prescaler #(
        .CODE_W (PCODEW),
        .CNT_W  (PCNTW)
    ) u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (sel_wr_en),
        .pre_code (sel_q[PCODEW-1:0]),
        .pre_tick (pre_tick),
        .pre_cnt  (pre_cnt),
        .pre_half (pre_half)
    );

    bgen_divider #(
        .CODE_W (DCODEW),
        .CNT_W  (DCNTW)
    ) u_div (
        .clk        (clk),
        .rst        (rst),
        .restart    (sel_wr_en),
        .pre_tick   (pre_tick),
        .div_code   (sel_q[PCODEW+DCODEW-1:PCODEW]),
        .div_last   (div_last),
        .bypass     (bypass),
        .div_cnt    (div_cnt),
        .period_len (period_len),
        .div_half   (div_half)
    );

    // Output stage
    always_ff @(posedge clk) begin
        if (rst || sel_wr_en) begin
            tick_q <= 1'b0;
            bclk_q <= 1'b0;
        end else begin
            tick_q <= pre_tick && div_last;
            bclk_q <= bypass ? (pre_cnt < pre_half) : (div_cnt < div_half);
        end
    end

    assign baud_tick = tick_q;
    assign baud_clk  = bclk_q;
    assign clk_out   = sel_q[MUX_BIT] ? bclk_q : clk;

endmodule

// File: rtl/bgen_checker.sv
module bgen_checker
    import bgen_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 sel_wr_en,
    input logic [SEL_W-1:0]     sel_q,
    input logic                 baud_tick,
    input logic                 baud_clk,
    input logic [PRE_CNT_W-1:0] pre_cnt,
    input logic [DIV_CNT_W-1:0] div_cnt,
    input logic [DIV_CNT_W-1:0] period_len
);

    p_pre_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        pre_cnt < pre_ratio(sel_q[PRE_CODE_W-1:0]))
        else $error("prescale counter beyond ratio");

    p_div_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        div_cnt < period_len)
        else $error("divisor counter beyond period");

    p_reset_mode_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !sel_q[SEL_W-1])
        else $error("mux bit survived reset");

    p_restart_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        sel_wr_en |=> (!baud_tick && !baud_clk))
        else $error("outputs active after restart");

    p_tick_narrow_r10: assert property (@(posedge clk) disable iff (rst)
        (baud_tick && sel_q[PRE_CODE_W-1:0] != 2'b00) |=> !baud_tick)
        else $error("tick wider than one cycle");

endmodule

bind prescaled_baud_gen bgen_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_wr_en  (sel_wr_en),
    .sel_q      (sel_q),
    .baud_tick  (baud_tick),
    .baud_clk   (baud_clk),
    .pre_cnt    (pre_cnt),
    .div_cnt    (div_cnt),
    .period_len (period_len)
);

// File: tb/prescaled_baud_gen_tb_top.sv
module prescaled_baud_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_wr_en = 1'b0;
    logic [7:0] sel_wr_data = 8'h00;
    logic       baud_tick;
    logic       baud_clk;
    logic       clk_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string cur_tag = "R9";

    // reference model state
    int m_pre = 0, m_div = 0, m_ph = 0;
    bit m_tick = 0, m_bclk = 0;
    bit [7:0] m_sel = 8'h00;
    bit cmp_en = 0;

    int gap_q[$];
    int since = 0;

    always #4 clk = ~clk;

    prescaled_baud_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .sel_wr_en   (sel_wr_en),
        .sel_wr_data (sel_wr_data),
        .baud_tick   (baud_tick),
        .baud_clk    (baud_clk),
        .clk_out     (clk_out)
    );

    function automatic int ratio_of(bit [1:0] c);
        int r[4] = '{1, 3, 4, 5};
        return r[c];
    endfunction

    function automatic int len_of(bit [4:0] c, int ph);
        case (c)
            1: return 4;     3: return 8;     5: return 16;    7: return 22;
            8: return 32;    9: return 64;    10: return 128;  11: return 192;
            12: return 256;  13: return 288;  14: return 352;  15: return 512;
            16: return 768;  31: return 1;
            2: return (ph == 2) ? 6 : 5;
            4: return (ph == 2) ? 10 : 11;
            6: return (ph == 2) ? 20 : 19;
            default: return 2;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced at the same edge as the design
    always @(posedge clk) begin
        cycles++;
        cmp_en = 1;
        if (sel_wr_en) m_sel[6:0] = sel_wr_data[6:0];
        if (rst) m_sel[7] = 0;
        else if (sel_wr_en) m_sel[7] = sel_wr_data[7];
        if (rst || sel_wr_en) begin
            m_pre = 0; m_div = 0; m_ph = 0; m_tick = 0; m_bclk = 0;
        end else begin
            int p, l;
            bit pt, lst, byp, frac;
            p    = ratio_of(m_sel[1:0]);
            byp  = (m_sel[6:2] == 5'd31);
            frac = (m_sel[6:2] == 5'd2 || m_sel[6:2] == 5'd4 || m_sel[6:2] == 5'd6);
            l    = len_of(m_sel[6:2], m_ph);
            pt   = (m_pre == p - 1);
            lst  = (m_div == l - 1);
            m_tick = pt && lst;
            m_bclk = byp ? (m_pre < (p + 1) / 2) : (m_div < (l + 1) / 2);
            m_pre  = pt ? 0 : m_pre + 1;
            if (pt) begin
                m_div = lst ? 0 : m_div + 1;
                if (lst && frac) m_ph = (m_ph + 1) % 3;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        since++;
        if (baud_tick) begin
            gap_q.push_back(since);
            since = 0;
        end
        if (cmp_en) begin
            check(cur_tag, baud_tick, m_tick, "baud_tick vs model");
            check(cur_tag, baud_clk, m_bclk, "baud_clk vs model");
            check(m_sel[7] ? "R7" : cur_tag, clk_out, m_sel[7] ? m_bclk : 0, "clk_out low phase");
        end
    end

    task automatic arm();
        gap_q.delete();
        since = 0;
    endtask

    task automatic write_sel(bit [7:0] v);
        @(negedge clk);
        sel_wr_en = 1'b1;
        sel_wr_data = v;
        @(posedge clk);
        #1;
        sel_wr_en = 1'b0;
        arm();
    endtask

    task automatic check_gaps(string tag, int p, int a, int b, int c, int n);
        int pat[3];
        pat = '{a, b, c};
        while (gap_q.size() < n + 1) @(posedge clk);
        #1;
        check("R8", gap_q[0], p * a + 1, {tag, " first tick after restart"});
        for (int i = 1; i <= n; i++)
            check(tag, gap_q[i], p * pat[i % 3], "tick gap");
    endtask

    task automatic check_raw_high();
        @(posedge clk);
        #2;
        check("R7", clk_out, 1, "raw clock on clk_out high phase");
    endtask

    initial begin
        // R9: reset with a select write during reset
        sel_wr_en = 1'b1;
        sel_wr_data = 8'h80;
        repeat (3) @(posedge clk);
        #1;
        sel_wr_en = 1'b0;
        @(negedge clk);
        check("R9", baud_tick, 0, "tick in reset");
        check("R9", baud_clk, 0, "baud_clk in reset");
        check("R7", clk_out, 0, "mux bit cleared by reset");
        @(posedge clk);
        #1 rst = 1'b0;
        arm();
        cur_tag = "R9";
        check_gaps("R9", 1, 2, 2, 2, 3);

        cur_tag = "R2"; write_sel(8'h00); check_gaps("R2", 1, 2, 2, 2, 4);
        cur_tag = "R1"; write_sel(8'h01); check_gaps("R1", 3, 2, 2, 2, 3);
        cur_tag = "R1"; write_sel(8'h06); check_gaps("R1", 4, 4, 4, 4, 3);
        cur_tag = "R1"; write_sel(8'h07); check_gaps("R1", 5, 4, 4, 4, 3);
        cur_tag = "R2"; write_sel(8'h1C); check_gaps("R2", 1, 22, 22, 22, 2);
        cur_tag = "R2"; write_sel(8'h3C); check_gaps("R2", 1, 512, 512, 512, 2);
        cur_tag = "R2"; write_sel(8'h41); check_gaps("R2", 3, 768, 768, 768, 2);
        cur_tag = "R6"; write_sel(8'h14); check_gaps("R6", 1, 16, 16, 16, 2);
        cur_tag = "R3"; write_sel(8'h08); check_gaps("R3", 1, 5, 5, 6, 6);
        cur_tag = "R3"; write_sel(8'h11); check_gaps("R3", 3, 11, 11, 10, 6);
        cur_tag = "R3"; write_sel(8'h18); check_gaps("R3", 1, 19, 19, 20, 6);
        cur_tag = "R5"; write_sel(8'h44); check_gaps("R5", 1, 2, 2, 2, 4);
        cur_tag = "R5"; write_sel(8'h7B); check_gaps("R5", 5, 2, 2, 2, 3);
        cur_tag = "R4"; write_sel(8'h7C); check_gaps("R4", 1, 1, 1, 1, 5);
        cur_tag = "R4"; write_sel(8'h7D); check_gaps("R4", 3, 1, 1, 1, 4);
        cur_tag = "R4"; write_sel(8'h7F); check_gaps("R4", 5, 1, 1, 1, 4);
        cur_tag = "R10"; write_sel(8'h05); check_gaps("R10", 3, 4, 4, 4, 3);

        // R7: baud clock routed to clk_out, then raw clock
        cur_tag = "R7"; write_sel(8'h82); check_gaps("R7", 4, 2, 2, 2, 3);
        write_sel(8'h02);
        check_raw_high();

        // R7: reset clears the mux bit but keeps divider fields (P=5, L=4)
        cur_tag = "R7"; write_sel(8'h87);
        repeat (10) @(posedge clk);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        arm();
        check_raw_high();
        check_gaps("R7", 5, 4, 4, 4, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule